// File: doc/BRIEF.md
# Lane Shift, Select and Group Remap Unit

This block reorders the byte lanes of a wide vector at streaming rate, one vector per clock, with no stall path. The vector is split into groups of sixteen byte lanes, and the number of groups is a parameter (twenty by default, 320 lanes in all). Two whole-vector shifters run side by side. One moves every byte toward higher lane indices and the other toward lower indices, each by its own programmable lane count. Lanes vacated at either end of the full vector read as zero.

A per-lane selector then chooses, for each lane, the unshifted byte, the up-shifted byte or the down-shifted byte. After that, a remap stage rebuilds each group of sixteen lanes from a programmed map. For each output lane the map names a source lane inside the same group, or forces that lane to zero. The same map is applied to every group, so one map can reverse, rotate, replicate or mask lanes across the whole vector.

The configuration inputs are sampled together with each accepted vector. Every vector therefore carries its own shift amounts, select codes and map through the pipeline, and a configuration change affects only the vectors accepted after it.

Top module: `lssd_unit`

## Requirements
- R1: A vector accepted on a rising edge with `in_valid` high appears with `out_valid` high after the second following rising edge. `out_valid` is high in exactly the cycles that match an accepted input. Vectors may be presented on consecutive cycles with no stall.
- R2: While `rst_n` is low, and in the first cycle after it rises, `out_valid` is low.
- R3: A select code of 0 or 3 (bits [2i+1:2i] of `cfg_sel`) passes the unshifted byte of lane i to the remap stage.
- R4: Select code 1 takes the up-shifted byte. Lane i receives input lane i-`cfg_up_amt`, or zero when i < `cfg_up_amt`.
- R5: Select code 2 takes the down-shifted byte. Lane i receives input lane i+`cfg_dn_amt`, or zero when that index is past the last lane.
- R6: Shifts act on the whole vector and cross group boundaries. A shift amount equal to or larger than the total lane count yields all zero bytes.
- R7: For output lane j of a group, map bits [5j+3:5j] name the source lane within that group. Several output lanes may name the same source.
- R8: When map bit 5j+4 is set, output lane j of every group is zero, whatever its source field says.
- R9: One map applies to all groups. Each group draws only on its own sixteen lanes.
- R10: The shift amounts, select codes and map are taken in the cycle the vector is accepted. Values driven while `in_valid` is low, or presented with a later vector, do not affect a vector already accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input vector is present this cycle |
| in_data | input | NUM_GROUPS*128 | Input vector, lane i in bits [8i+7:8i] |
| cfg_up_amt | input | clog2(NUM_GROUPS*16+1) | Lane count for the up shifter |
| cfg_dn_amt | input | clog2(NUM_GROUPS*16+1) | Lane count for the down shifter |
| cfg_sel | input | NUM_GROUPS*32 | Two-bit select code per lane |
| cfg_map | input | 80 | Group remap: per output lane, a 4-bit source and a zero bit |
| out_valid | output | 1 | Output vector is present this cycle |
| out_data | output | NUM_GROUPS*128 | Output vector |

## Verification
The bench builds the unit with four groups (64 lanes), which gives a 7-bit shift amount. With that size, amounts of 20 and 33 cross several group boundaries, and amounts of 64 and 100 go past the whole vector to test the all-zero case. Four groups are enough to show that the shared map never mixes lanes between groups, and to make sure the top and bottom lanes of the vector are checked for zero fill. Back-to-back vectors, each with a different configuration, together with idle cycles that drive unrelated configuration values, test that each vector keeps the settings it was accepted with.

// File: rtl/lssd_pkg.sv
package lssd_pkg;

  localparam int BYTE_W       = 8;
  localparam int BYTE_SH      = $clog2(BYTE_W);
  localparam int GROUP_LANES  = 16;
  localparam int SRC_W        = $clog2(GROUP_LANES);
  localparam int MAP_ENTRY_W  = SRC_W + 1;
  localparam int MAP_W        = GROUP_LANES * MAP_ENTRY_W;
  localparam int GROUP_W      = GROUP_LANES * BYTE_W;
  localparam int LANE_SEL_W   = 2;

  typedef enum logic [LANE_SEL_W-1:0] {
    SEL_PASS     = 2'd0,
    SEL_UP       = 2'd1,
    SEL_DOWN     = 2'd2,
    SEL_PASS_ALT = 2'd3
  } lane_sel_e;

  // Map that sends every lane to itself with no zero fill.
  function automatic logic [MAP_W-1:0] identity_map();
    logic [MAP_W-1:0] m;
    for (int j = 0; j < GROUP_LANES; j++) begin
      m[j*MAP_ENTRY_W +: MAP_ENTRY_W] = {1'b0, SRC_W'(j)};
    end
    return m;
  endfunction

endpackage

// File: rtl/lssd_rst_sync.sv
module lssd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/lssd_shift.sv
module lssd_shift #(
  parameter int VEC_W    = 2560,
  parameter int AMT_W    = 9,
  parameter bit SHIFT_UP = 1'b1
) (
  input  logic [VEC_W-1:0] vec_in,
  input  logic [AMT_W-1:0] amt,
  output logic [VEC_W-1:0] vec_out
);
  import lssd_pkg::*;

  localparam int BIT_AMT_W = AMT_W + BYTE_SH;

  logic [BIT_AMT_W-1:0] bit_amt;

  // Lane count scaled to a bit count; logical shifts fill vacated lanes with zero.
  assign bit_amt = {amt, {BYTE_SH{1'b0}}};

  generate
    if (SHIFT_UP) begin : g_up
      assign vec_out = vec_in << bit_amt;
    end else begin : g_down
      assign vec_out = vec_in >> bit_amt;
    end
  endgenerate

endmodule

// File: rtl/lssd_lane_select.sv
module lssd_lane_select #(
  parameter int LANES = 320
) (
  input  logic [LANES*8-1:0]  pass_vec,
  input  logic [LANES*8-1:0]  up_vec,
  input  logic [LANES*8-1:0]  dn_vec,
  input  logic [LANES*2-1:0]  sel,
  output logic [LANES*8-1:0]  sel_vec
);
  import lssd_pkg::*;

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      lane_sel_e code;
      assign code = lane_sel_e'(sel[i*LANE_SEL_W +: LANE_SEL_W]);

      always_comb begin
        case (code)
          SEL_UP:   sel_vec[i*BYTE_W +: BYTE_W] = up_vec[i*BYTE_W +: BYTE_W];
          SEL_DOWN: sel_vec[i*BYTE_W +: BYTE_W] = dn_vec[i*BYTE_W +: BYTE_W];
          default:  sel_vec[i*BYTE_W +: BYTE_W] = pass_vec[i*BYTE_W +: BYTE_W];
        endcase
      end
    end
  endgenerate

endmodule

// File: rtl/lssd_group_remap.sv
module lssd_group_remap (
  input  logic [lssd_pkg::GROUP_W-1:0] grp_in,
  input  logic [lssd_pkg::MAP_W-1:0]   map,
  output logic [lssd_pkg::GROUP_W-1:0] grp_out
);
  import lssd_pkg::*;

  generate
    for (genvar j = 0; j < GROUP_LANES; j++) begin : g_out_lane
      logic [MAP_ENTRY_W-1:0] entry;
      logic [SRC_W-1:0]       src;
      logic                   zero_fill;

      assign entry     = map[j*MAP_ENTRY_W +: MAP_ENTRY_W];
      assign src       = entry[SRC_W-1:0];
      assign zero_fill = entry[SRC_W];

      always_comb begin
        if (zero_fill) begin
          grp_out[j*BYTE_W +: BYTE_W] = '0;
        end else begin
          grp_out[j*BYTE_W +: BYTE_W] = grp_in[{src, {BYTE_SH{1'b0}}} +: BYTE_W];
        end
      end
    end
  endgenerate

endmodule

// File: rtl/lssd_unit.sv
module lssd_unit
  import lssd_pkg::*;
#(
  parameter int NUM_GROUPS = 20
) (
  input  logic                                             clk,
  input  logic                                             rst_n,
  input  logic                                             in_valid,
  input  logic [NUM_GROUPS*GROUP_W-1:0]                    in_data,
  input  logic [$clog2(NUM_GROUPS*GROUP_LANES+1)-1:0]      cfg_up_amt,
  input  logic [$clog2(NUM_GROUPS*GROUP_LANES+1)-1:0]      cfg_dn_amt,
  input  logic [NUM_GROUPS*GROUP_LANES*LANE_SEL_W-1:0]     cfg_sel,
  input  logic [MAP_W-1:0]                                 cfg_map,
  output logic                                             out_valid,
  output logic [NUM_GROUPS*GROUP_W-1:0]                    out_data
);

  localparam int LANES = NUM_GROUPS * GROUP_LANES;
  localparam int VEC_W = LANES * BYTE_W;
  localparam int AMT_W = $clog2(LANES + 1);

  logic             rst_n_sync;
  logic [VEC_W-1:0] up_vec;
  logic [VEC_W-1:0] dn_vec;
  logic [VEC_W-1:0] sel_vec;
  logic [VEC_W-1:0] remap_vec;

  // Stage 1: shifted/selected vector plus the map captured with it.
  logic             s1_valid_d, s1_valid_q;
  logic             s1_en;
  logic [VEC_W-1:0] s1_data_q;
  logic [MAP_W-1:0] s1_map_q;

  // Stage 2: remapped output.
  logic             s2_valid_d, s2_valid_q;
  logic             s2_en;
  logic [VEC_W-1:0] s2_data_q;

  lssd_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  lssd_shift #(.VEC_W(VEC_W), .AMT_W(AMT_W), .SHIFT_UP(1'b1)) u_shift_up (
    .vec_in  (in_data),
    .amt     (cfg_up_amt),
    .vec_out (up_vec)
  );

  lssd_shift #(.VEC_W(VEC_W), .AMT_W(AMT_W), .SHIFT_UP(1'b0)) u_shift_dn (
    .vec_in  (in_data),
    .amt     (cfg_dn_amt),
    .vec_out (dn_vec)
  );

  lssd_lane_select #(.LANES(LANES)) u_select (
    .pass_vec (in_data),
    .up_vec   (up_vec),
    .dn_vec   (dn_vec),
    .sel      (cfg_sel),
    .sel_vec  (sel_vec)
  );

  // Next-state logic
  always_comb begin
    s1_en      = in_valid;
    s1_valid_d = in_valid;
    s2_en      = s1_valid_q;
    s2_valid_d = s1_valid_q;
  end

  // Valid registers with reset
  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      s1_valid_q <= 1'b0;
      s2_valid_q <= 1'b0;
    end else begin
      s1_valid_q <= s1_valid_d;
      s2_valid_q <= s2_valid_d;
    end
  end

  // Stage 1 data registers, loaded only on an accepted vector
  always_ff @(posedge clk) begin
    if (s1_en) begin
      s1_data_q <= sel_vec;
      s1_map_q  <= cfg_map;
    end
  end

  generate
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_group
      lssd_group_remap u_remap (
        .grp_in  (s1_data_q[g*GROUP_W +: GROUP_W]),
        .map     (s1_map_q),
        .grp_out (remap_vec[g*GROUP_W +: GROUP_W])
      );
    end
  endgenerate

  // Stage 2 data registers
  always_ff @(posedge clk) begin
    if (s2_en) begin
      s2_data_q <= remap_vec;
    end
  end

  assign out_valid = s2_valid_q;
  assign out_data  = s2_data_q;

endmodule

// File: rtl/lssd_unit_chk.sv
module lssd_unit_chk
  import lssd_pkg::*;
#(
  parameter int NUM_GROUPS = 20
) (
  input logic                                         clk,
  input logic                                         rst_n,
  input logic                                         in_valid,
  input logic [NUM_GROUPS*GROUP_W-1:0]                in_data,
  input logic [$clog2(NUM_GROUPS*GROUP_LANES+1)-1:0]  cfg_up_amt,
  input logic [$clog2(NUM_GROUPS*GROUP_LANES+1)-1:0]  cfg_dn_amt,
  input logic [NUM_GROUPS*GROUP_LANES*LANE_SEL_W-1:0] cfg_sel,
  input logic [MAP_W-1:0]                             cfg_map,
  input logic                                         out_valid,
  input logic [NUM_GROUPS*GROUP_W-1:0]                out_data
);

  localparam int LANES = NUM_GROUPS * GROUP_LANES;
  localparam int VEC_W = LANES * BYTE_W;
  localparam int SEL_W = LANES * LANE_SEL_W;

  logic [1:0] cyc_q;
  logic       armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q <= 2'd0;
    end else if (cyc_q != 2'd3) begin
      cyc_q <= cyc_q + 2'd1;
    end
  end

  assign armed = (cyc_q >= 2'd2);

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> !out_valid); // R2

  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (out_valid == $past(in_valid, 2))); // R1

  AST_PASS_IDENTITY: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(in_valid, 2) && ($past(cfg_sel, 2) == {SEL_W{1'b0}})
      && ($past(cfg_map, 2) == identity_map()))
    |-> (out_data == $past(in_data, 2))); // R3

  AST_UP_LOW_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(in_valid, 2) && ($past(cfg_sel[1:0], 2) == SEL_UP)
      && ($past(cfg_map[MAP_ENTRY_W-1:0], 2) == '0) && ($past(cfg_up_amt, 2) != '0))
    |-> (out_data[BYTE_W-1:0] == '0)); // R4

  AST_DOWN_HIGH_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(in_valid, 2) && ($past(cfg_sel[SEL_W-1 -: LANE_SEL_W], 2) == SEL_DOWN)
      && ($past(cfg_map[MAP_W-1 -: MAP_ENTRY_W], 2) == {1'b0, {SRC_W{1'b1}}})
      && ($past(cfg_dn_amt, 2) != '0))
    |-> (out_data[VEC_W-1 -: BYTE_W] == '0)); // R5

  AST_ZERO_LANE0: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(in_valid, 2) && $past(cfg_map[SRC_W], 2))
    |-> (out_data[BYTE_W-1:0] == '0)); // R8

endmodule

bind lssd_unit lssd_unit_chk #(.NUM_GROUPS(NUM_GROUPS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_data    (in_data),
  .cfg_up_amt (cfg_up_amt),
  .cfg_dn_amt (cfg_dn_amt),
  .cfg_sel    (cfg_sel),
  .cfg_map    (cfg_map),
  .out_valid  (out_valid),
  .out_data   (out_data)
);

// File: tb/lssd_unit_tb.sv
module lssd_unit_tb;
  import lssd_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NG    = 4;
  localparam int L     = NG * GROUP_LANES;
  localparam int VW    = L * BYTE_W;
  localparam int AW    = $clog2(L + 1);
  localparam int SW    = L * LANE_SEL_W;

  logic          clk;
  logic          rst_n;
  logic          in_valid;
  logic [VW-1:0] in_data;
  logic [AW-1:0] cfg_up_amt;
  logic [AW-1:0] cfg_dn_amt;
  logic [SW-1:0] cfg_sel;
  logic [MAP_W-1:0] cfg_map;
  logic          out_valid;
  logic [VW-1:0] out_data;

  int checks;
  int errors;
  logic          started;
  logic          vp1, vp2;
  logic [VW-1:0] exp_q[$];
  string         tag_q[$];

  lssd_unit #(.NUM_GROUPS(NG)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .cfg_up_amt (cfg_up_amt),
    .cfg_dn_amt (cfg_dn_amt),
    .cfg_sel    (cfg_sel),
    .cfg_map    (cfg_map),
    .out_valid  (out_valid),
    .out_data   (out_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference model written from the requirements
  function automatic logic [VW-1:0] model(input logic [VW-1:0] d, input logic [AW-1:0] up,
                                          input logic [AW-1:0] dn, input logic [SW-1:0] sel,
                                          input logic [MAP_W-1:0] map);
    logic [7:0] s [L];
    logic [VW-1:0] r;
    for (int i = 0; i < L; i++) begin
      int src;
      case (sel[2*i +: 2])
        2'd1: begin src = i - int'(up); s[i] = (src >= 0) ? d[src*8 +: 8] : 8'h00; end
        2'd2: begin src = i + int'(dn); s[i] = (src < L) ? d[src*8 +: 8] : 8'h00; end
        default: s[i] = d[i*8 +: 8];
      endcase
    end
    for (int g = 0; g < NG; g++) begin
      for (int j = 0; j < 16; j++) begin
        logic [4:0] e;
        e = map[j*5 +: 5];
        r[(g*16+j)*8 +: 8] = e[4] ? 8'h00 : s[g*16 + int'(e[3:0])];
      end
    end
    return r;
  endfunction

  function automatic logic [VW-1:0] rand_vec();
    logic [VW-1:0] v;
    for (int k = 0; k < VW/32; k++) v[k*32 +: 32] = $urandom();
    return v;
  endfunction

  function automatic logic [SW-1:0] rand_sel();
    logic [SW-1:0] v;
    for (int k = 0; k < SW/32; k++) v[k*32 +: 32] = $urandom();
    return v;
  endfunction

  function automatic logic [MAP_W-1:0] rand_map(input bit with_zero);
    logic [MAP_W-1:0] m;
    for (int j = 0; j < 16; j++) begin
      m[j*5 +: 4] = 4'($urandom_range(0, 15));
      m[j*5 + 4]  = with_zero ? 1'($urandom_range(0, 1)) : 1'b0;
    end
    return m;
  endfunction

  function automatic logic [MAP_W-1:0] fill_map(input int mode);
    logic [MAP_W-1:0] m;
    for (int j = 0; j < 16; j++) begin
      case (mode)
        0: m[j*5 +: 5] = {1'b0, 4'(j)};
        1: m[j*5 +: 5] = {1'b0, 4'(15 - j)};
        2: m[j*5 +: 5] = {1'b0, 4'd3};
        3: m[j*5 +: 5] = {1'b1, 4'(j)};
        default: m[j*5 +: 5] = {1'b0, 4'((j + 5) % 16)};
      endcase
    end
    return m;
  endfunction

  function automatic logic [SW-1:0] all_sel(input logic [1:0] c);
    return {L{c}};
  endfunction

  task automatic send(input logic [VW-1:0] d, input int up, input int dn,
                      input logic [SW-1:0] sel, input logic [MAP_W-1:0] map, input string tag);
    @(negedge clk);
    in_valid   = 1'b1;
    in_data    = d;
    cfg_up_amt = AW'(up);
    cfg_dn_amt = AW'(dn);
    cfg_sel    = sel;
    cfg_map    = map;
    exp_q.push_back(model(d, AW'(up), AW'(dn), sel, map));
    tag_q.push_back(tag);
  endtask

  // Idle cycles drive unrelated configuration to show it is ignored (R10)
  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid   = 1'b0;
      in_data    = rand_vec();
      cfg_up_amt = AW'($urandom_range(0, L));
      cfg_dn_amt = AW'($urandom_range(0, L));
      cfg_sel    = rand_sel();
      cfg_map    = rand_map(1'b1);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // Expected valid timing, from the bench's own drive history
  always @(posedge clk) begin
    vp2 <= vp1;
    vp1 <= in_valid;
  end

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (started) begin
      checks++;
      if (out_valid !== vp2) begin
        errors++;
        $display("FAIL R1 out_valid got %b exp %b", out_valid, vp2);
      end
      if (out_valid === 1'b1) begin
        if (exp_q.size() == 0) begin
          checks++;
          errors++;
          $display("FAIL R1 unexpected output got 1 exp 0");
        end else begin
          logic [VW-1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          checks++;
          if (out_data !== e) begin
            errors++;
            $display("FAIL %s got %h exp %h", t, out_data, e);
          end
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    checks++;
    errors++;
    $display("FAIL watchdog expired got timeout exp completion");
    finish_run();
  end

  initial begin
    checks = 0;
    errors = 0;
    started = 1'b0;
    vp1 = 1'b0;
    vp2 = 1'b0;
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_data = '0;
    cfg_up_amt = '0;
    cfg_dn_amt = '0;
    cfg_sel = '0;
    cfg_map = '0;

    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R2 out_valid in reset got %b exp 0", out_valid);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R2 out_valid after release got %b exp 0", out_valid);
    end
    repeat (3) @(negedge clk);
    started = 1'b1;

    // R3: unshifted pass through, codes 0 and 3
    send(rand_vec(), 0, 0, all_sel(2'd0), fill_map(0), "R3 code0 identity");
    send(rand_vec(), 9, 9, all_sel(2'd3), fill_map(0), "R3 code3 identity");
    // R4 / R5: whole-vector shifts with end fill
    send(rand_vec(), 5, 0, all_sel(2'd1), fill_map(0), "R4 up by 5");
    send(rand_vec(), 0, 7, all_sel(2'd2), fill_map(0), "R5 down by 7");
    send(rand_vec(), 0, 0, all_sel(2'd1), fill_map(0), "R4 up by 0");
    // R6: across groups and past the end
    send(rand_vec(), 20, 0, all_sel(2'd1), fill_map(0), "R6 up by 20");
    send(rand_vec(), 0, 33, all_sel(2'd2), fill_map(0), "R6 down by 33");
    send(rand_vec(), L, 0, all_sel(2'd1), fill_map(0), "R6 up by full length");
    send(rand_vec(), 0, 100, all_sel(2'd2), fill_map(0), "R6 down past end");
    idle(2);
    // Mixed per-lane selection
    for (int k = 0; k < 6; k++) begin
      send(rand_vec(), $urandom_range(0, L), $urandom_range(0, L), rand_sel(),
           fill_map(0), "R3 R4 R5 mixed select");
    end
    // R7: rearrange and replicate; R9: same map on every group
    send(rand_vec(), 0, 0, all_sel(2'd0), fill_map(1), "R7 reverse map");
    send(rand_vec(), 0, 0, all_sel(2'd0), fill_map(2), "R7 broadcast lane 3");
    send(rand_vec(), 0, 0, all_sel(2'd0), fill_map(4), "R9 rotate map all groups");
    send(rand_vec(), 3, 0, all_sel(2'd1), fill_map(1), "R9 up shift then reverse");
    // R8: zero fill
    send(rand_vec(), 0, 0, all_sel(2'd0), fill_map(3), "R8 all lanes zeroed");
    for (int k = 0; k < 4; k++) begin
      send(rand_vec(), 0, 0, all_sel(2'd0), rand_map(1'b1), "R8 random zero bits");
    end
    idle(3);
    // R10: every vector carries its own configuration, back to back
    for (int k = 0; k < 12; k++) begin
      send(rand_vec(), $urandom_range(0, L), $urandom_range(0, L), rand_sel(),
           rand_map(1'b1), "R10 back-to-back config change");
    end
    // R1: irregular gaps
    for (int k = 0; k < 8; k++) begin
      send(rand_vec(), $urandom_range(0, 16), $urandom_range(0, 16), rand_sel(),
           rand_map(1'b0), "R1 gapped stream");
      idle(k % 3);
    end
    idle(6);

    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R1 outputs missing got %0d left exp 0", exp_q.size());
    end
    finish_run();
  end

endmodule